// File: doc/BRIEF.md
# Streaming Defective Pixel Corrector

This block repairs a known set of dead sensor pixels while a raster image streams through it. Before pixels flow, a loader writes the defect coordinates into an on-chip table through a small write port. It then commits the number of valid entries. This port stands in for whatever reads the list out of non-volatile storage. The table must be sorted in raster order (by row, then by column). Because of that ordering, only one table entry can be the next defect. Each incoming pixel is compared against that single entry, and no bank of comparators is needed. A synchronous read, addressed by the pointer's next value, fetches the following entry one cycle ahead. Back-to-back defects are therefore still caught.

The block tracks the column and row of every valid pixel. A frame starts with a start-of-frame marker and each line closes with an end-of-line marker. Within a line, pixels must arrive on consecutive cycles; gaps are allowed only between lines. A defective pixel with a left neighbour takes the value already emitted for that neighbour. A defective pixel in column zero takes the raw value of the pixel after it. That look-ahead sets a fixed two-cycle delay on every pixel and marker, whether or not the pixel was repaired.

Top module: `pixfix`

## Requirements
- R1: out_valid, out_sof and out_eol equal in_valid, in_valid&&in_sof and in_valid&&in_eol from exactly two clock cycles earlier, for every pixel, whether corrected or not.
- R2: A pixel that is not in the active part of the table leaves with the same value it entered with; with no list committed since reset, every pixel passes unchanged.
- R3: A pulse of ld_we writes entry ld_idx with column ld_x and row ld_y. A pulse of ld_commit sets the active entry count to ld_num, clamped to MAX_DEF.
- R4: ld_we and ld_commit have no effect while a frame is active or while in_valid is high. A frame is active from a valid start-of-frame pixel through the valid end-of-line pixel of row ROWS-1.
- R5: The start-of-frame pixel is at column 0, row 0. Each valid pixel advances the column by one. A valid end-of-line pixel returns the column to 0 and advances the row.
- R6: Each pixel is compared only with the next unmatched entry, and a match advances to the entry after it. At every start of frame the comparison restarts at entry 0, so repeated frames are corrected identically.
- R7: Only entries 0 to count-1 are used; table entries at or beyond the committed count never cause a correction.
- R8: A defective pixel at a column above 0 is replaced by the output value of the previous pixel of its line, so a run of adjacent defects all take the last good value before the run.
- R9: A defective pixel at column 0 is replaced by the raw input value of the pixel at column 1 of its line. When the line is one pixel long, the pixel passes unchanged.
- R10: list_ready is 0 after reset and becomes 1 in the cycle after an accepted ld_commit. Once it is 1, it stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_we | input | 1 | Write one defect table entry |
| ld_idx | input | IDX_W | Table entry index |
| ld_x | input | X_W | Defect column |
| ld_y | input | Y_W | Defect row |
| ld_commit | input | 1 | Set the active entry count |
| ld_num | input | CNT_W | Number of active entries |
| list_ready | output | 1 | A defect list has been committed |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_pix | input | PIX_W | Input pixel value |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | First output pixel of a frame |
| out_eol | output | 1 | Last output pixel of a line |
| out_pix | output | PIX_W | Output pixel value, corrected where defective |

## Verification
The assertions check on every cycle that:
- the valid and marker outputs lag the inputs by exactly two cycles;
- every pixel passes untouched before any list exists;
- list_ready can only rise after a commit outside an active frame, and never falls.

Which pixels get replaced, and by what, depends on the table contents and the frame geometry. Only the bench's frames can show this:
- adjacent defects;
- defects in column zero and in the last column;
- a shortened entry count;
- one-pixel lines;
- a repeated frame that proves the pointer rewinds;
- a load attempted between lines of an active frame.

// File: rtl/pixfix.sv
module pixfix #(
  parameter int PIX_W   = 8,
  parameter int X_W     = 11,
  parameter int Y_W     = 11,
  parameter int ROWS    = 1080,
  parameter int MAX_DEF = 100,
  localparam int IDX_W  = $clog2(MAX_DEF),
  localparam int CNT_W  = $clog2(MAX_DEF + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [X_W-1:0]   ld_x,
  input  logic [Y_W-1:0]   ld_y,
  input  logic             ld_commit,
  input  logic [CNT_W-1:0] ld_num,
  output logic             list_ready,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eol,
  output logic [PIX_W-1:0] out_pix
);
  localparam int ENT_W = X_W + Y_W;

  logic [ENT_W-1:0] list_mem [MAX_DEF];
  logic [ENT_W-1:0] head, ent, cmp_ent;
  logic [CNT_W-1:0] count, ptr, base_ptr, ptr_d;
  logic [X_W-1:0]   cx, pos_x;
  logic [Y_W-1:0]   cy, pos_y;
  logic             frame_act, load_ok, sof_v, hit;
  logic             v1, sof1, eol1, bad1, first1;
  logic [PIX_W-1:0] p1;

  assign load_ok  = !frame_act && !in_valid;
  assign sof_v    = in_valid && in_sof;
  assign pos_x    = sof_v ? '0 : cx;
  assign pos_y    = sof_v ? '0 : cy;
  assign cmp_ent  = sof_v ? head : ent;
  assign base_ptr = sof_v ? '0 : ptr;
  assign hit      = in_valid && (base_ptr < count) && (cmp_ent == {pos_y, pos_x});
  assign ptr_d    = in_valid ? base_ptr + CNT_W'(hit) : ptr;

  always_ff @(posedge clk)
    if (ld_we && load_ok && int'(ld_idx) < MAX_DEF)
      list_mem[ld_idx] <= {ld_y, ld_x};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head       <= '0;
      count      <= '0;
      list_ready <= 1'b0;
    end else if (load_ok) begin
      if (ld_we && ld_idx == '0) head <= {ld_y, ld_x};
      if (ld_commit) begin
        count      <= (int'(ld_num) > MAX_DEF) ? CNT_W'(MAX_DEF) : ld_num;
        list_ready <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      ent <= '0;
    end else begin
      ptr <= ptr_d;
      ent <= (int'(ptr_d) < MAX_DEF) ? list_mem[ptr_d[IDX_W-1:0]] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cx        <= '0;
      cy        <= '0;
      frame_act <= 1'b0;
    end else if (in_valid) begin
      if (in_eol) begin
        cx <= '0;
        cy <= pos_y + Y_W'(1);
      end else begin
        cx <= pos_x + X_W'(1);
        cy <= pos_y;
      end
      if (sof_v) frame_act <= 1'b1;
      if (in_eol && pos_y == Y_W'(ROWS - 1)) frame_act <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      sof1   <= 1'b0;
      eol1   <= 1'b0;
      bad1   <= 1'b0;
      first1 <= 1'b0;
      p1     <= '0;
    end else begin
      v1     <= in_valid;
      sof1   <= sof_v;
      eol1   <= in_valid && in_eol;
      bad1   <= hit;
      first1 <= in_valid && pos_x == '0;
      p1     <= in_pix;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= v1;
      out_sof   <= sof1;
      out_eol   <= eol1;
      if (v1) begin
        if (!bad1)       out_pix <= p1;
        else if (!first1) out_pix <= out_pix;
        else if (eol1)   out_pix <= p1;
        else             out_pix <= in_pix;
      end
    end
  end
endmodule

// File: rtl/pixfix_chk.sv
module pixfix_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_eol,
  input logic [PIX_W-1:0] in_pix,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eol,
  input logic [PIX_W-1:0] out_pix,
  input logic             list_ready,
  input logic             ld_commit,
  input logic             frame_act
);
  logic [1:0] age;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  assign warm = age >= 2'd2;

  p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> out_valid == $past(in_valid, 2));

  p_marker_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_sof == $past(in_valid && in_sof, 2)) && (out_eol == $past(in_valid && in_eol, 2)));

  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !list_ready && out_valid) |-> out_pix == $past(in_pix, 2));

  p_commit_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(list_ready) |-> $past(ld_commit && !frame_act && !in_valid));

  p_ready_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    list_ready |=> list_ready);
endmodule

bind pixfix pixfix_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
  .in_pix(in_pix), .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
  .out_pix(out_pix), .list_ready(list_ready), .ld_commit(ld_commit), .frame_act(frame_act)
);

// File: tb/tb_pixfix.sv
`timescale 1ns/1ps
module tb_pixfix;
  localparam int PIX_W = 8, X_W = 11, Y_W = 11, ROWS = 4, MAX_DEF = 100;
  localparam int IDX_W = $clog2(MAX_DEF), CNT_W = $clog2(MAX_DEF + 1);

  localparam int DEF_X [7] = '{0, 3, 4, 7, 0, 2, 3};
  localparam int DEF_Y [7] = '{0, 0, 0, 1, 2, 3, 3};
  localparam int SCN_CNT [3] = '{7, 3, 7};

  logic clk = 0, rst_n = 0;
  logic ld_we = 0, ld_commit = 0;
  logic [IDX_W-1:0] ld_idx = '0;
  logic [X_W-1:0] ld_x = '0;
  logic [Y_W-1:0] ld_y = '0;
  logic [CNT_W-1:0] ld_num = '0;
  logic list_ready;
  logic in_valid = 0, in_sof = 0, in_eol = 0;
  logic [PIX_W-1:0] in_pix = '0;
  logic out_valid, out_sof, out_eol;
  logic [PIX_W-1:0] out_pix;

  int tests = 0, fails = 0;
  int cyc = 0;
  int n_in = 0, n_out = 0;
  int in_cyc [64];
  int out_cyc [64];
  logic [PIX_W-1:0] out_buf [64];
  logic out_sof_b [64];
  logic out_eol_b [64];
  int lx [8];
  int ly [8];
  int act_n = 0;

  always #2.5 clk = ~clk;

  pixfix #(.PIX_W(PIX_W), .X_W(X_W), .Y_W(Y_W), .ROWS(ROWS), .MAX_DEF(MAX_DEF)) dut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_idx(ld_idx), .ld_x(ld_x), .ld_y(ld_y),
    .ld_commit(ld_commit), .ld_num(ld_num), .list_ready(list_ready),
    .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol), .in_pix(in_pix),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix));

  always @(posedge clk) begin
    if (in_valid && n_in < 64) begin
      in_cyc[n_in] = cyc;
      n_in = n_in + 1;
    end
    cyc <= cyc + 1;
  end

  always @(negedge clk)
    if (out_valid && n_out < 64) begin
      out_cyc[n_out] = cyc;
      out_buf[n_out] = out_pix;
      out_sof_b[n_out] = out_sof;
      out_eol_b[n_out] = out_eol;
      n_out = n_out + 1;
    end

  function automatic logic [PIX_W-1:0] pix(int x, int y);
    return PIX_W'(y * 37 + x * 11 + 3);
  endfunction

  function automatic bit is_bad(int x, int y);
    for (int k = 0; k < act_n; k++)
      if (lx[k] == x && ly[k] == y) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_entry(int idx, int x, int y);
    @(negedge clk);
    ld_we = 1; ld_idx = IDX_W'(idx); ld_x = X_W'(x); ld_y = Y_W'(y);
    @(negedge clk);
    ld_we = 0;
  endtask

  task automatic commit(int n);
    @(negedge clk);
    ld_commit = 1; ld_num = CNT_W'(n);
    @(negedge clk);
    ld_commit = 0;
  endtask

  task automatic run_frame(int w, bit inject);
    n_in = 0; n_out = 0;
    for (int y = 0; y < ROWS; y++) begin
      for (int x = 0; x < w; x++) begin
        @(negedge clk);
        in_valid = 1; in_sof = (x == 0 && y == 0); in_eol = (x == w - 1); in_pix = pix(x, y);
      end
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eol = 0;
      if (inject && y == 1) begin
        ld_we = 1; ld_idx = '0; ld_x = X_W'(9); ld_y = Y_W'(9);
        ld_commit = 1; ld_num = CNT_W'(7);
        @(negedge clk);
        ld_we = 0; ld_commit = 0;
      end
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_frame(int w, string tag);
    logic [PIX_W-1:0] e, prev;
    int bad_idx = -1, bad_act = 0, bad_exp = 0;
    int lat_bad = -1, mk_bad = -1;
    chk(n_out == w * ROWS, "R1 pixel count", n_out, w * ROWS);
    prev = '0;
    for (int y = 0; y < ROWS; y++)
      for (int x = 0; x < w; x++) begin
        int i = y * w + x;
        e = pix(x, y);
        if (is_bad(x, y)) e = (x > 0) ? prev : ((w > 1) ? pix(1, y) : pix(0, y));
        prev = e;
        if (i < n_out && bad_idx < 0 && out_buf[i] !== e) begin
          bad_idx = i; bad_act = int'(out_buf[i]); bad_exp = int'(e);
        end
        if (i < n_out && lat_bad < 0 && out_cyc[i] - in_cyc[i] != 2) lat_bad = out_cyc[i] - in_cyc[i];
        if (i < n_out && mk_bad < 0 &&
            (out_sof_b[i] !== (i == 0) || out_eol_b[i] !== (x == w - 1))) mk_bad = i;
      end
    chk(bad_idx < 0, tag, bad_act, bad_exp);
    chk(lat_bad < 0, "R1 two-cycle latency", lat_bad, 2);
    chk(mk_bad < 0, "R1 R5 markers", mk_bad, -1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 reset out_valid", int'(out_valid), 0);
    chk(list_ready == 0, "R10 reset list_ready", int'(list_ready), 0);

    for (int k = 0; k < 7; k++) load_entry(k, DEF_X[k], DEF_Y[k]);
    act_n = 0;
    run_frame(8, 1'b1);
    check_frame(8, "R2 R4 passthrough with no list");
    chk(list_ready == 0, "R4 commit during frame ignored", int'(list_ready), 0);

    for (int s = 0; s < 3; s++) begin
      commit(SCN_CNT[s]);
      chk(list_ready == 1, "R3 R10 list_ready after commit", int'(list_ready), 1);
      act_n = SCN_CNT[s];
      for (int k = 0; k < act_n; k++) begin lx[k] = DEF_X[k]; ly[k] = DEF_Y[k]; end
      run_frame(8, 1'b0);
      check_frame(8, "R3 R4 R5 R6 R7 R8 R9 corrected frame");
    end

    load_entry(0, 0, 1);
    load_entry(1, 1, 2);
    commit(2);
    act_n = 2; lx[0] = 0; ly[0] = 1; lx[1] = 1; ly[1] = 2;
    run_frame(2, 1'b0);
    check_frame(2, "R9 R8 two-pixel lines");

    commit(1);
    act_n = 1;
    run_frame(1, 1'b0);
    check_frame(1, "R9 one-pixel line unchanged");
    chk(list_ready == 1, "R10 list_ready stays", int'(list_ready), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule